// File: doc/BRIEF.md
# Receive Descriptor Ring Write Engine

This block takes incoming packets one byte at a time, stores each whole packet in an internal buffer, and then places it in host memory through a ring of receive descriptors. Each descriptor is eight bytes long. Bytes 0 to 3 hold a 32-bit buffer address. Bytes 4 and 5 hold a 16-bit length, which on read is the buffer's capacity. Bytes 6 and 7 hold a 16-bit flags word. As seen through a 32-bit little-endian word read at offset 4, the length is in bits 15:0 and the flags are in bits 31:16. The flags bit 15 that marks a descriptor as available is therefore word bit 31.

When a packet has been captured, the engine searches the ring for a free descriptor, first fit, starting at its running index. It copies the packet into that descriptor's buffer and rewrites the descriptor's length and flags. It then pulses a word that sets the receive bit in an interrupt-status register held elsewhere. If the packet is too large, or no descriptor can take it, the packet is discarded and a drop pulse is given instead. The input stream is stalled while a packet is being placed, so only one packet is handled at a time.

The memory port is a simple request port. A request is held until it is granted. A read returns its data on a later cycle, flagged by a valid strobe, with one request outstanding at a time.

Top module: `rx_ring_writer`

## Requirements
- R1: The number of descriptors in the ring is `rx_ring_len_m1` + 1. One search reads the length/flags word (offset 4) of at most that many descriptors.
- R2: The search begins at the running index and moves forward, wrapping from the last descriptor to descriptor 0. The index steps past every descriptor inspected, skipped or taken, and keeps its value from one packet to the next.
- R3: A descriptor is taken only if word bit 31 (flags bit 15) is set and its length field is greater than or equal to the packet size. A length equal to the packet size fits. Descriptors that are not taken are never written.
- R4: Packet byte n is written to buffer address + n as a single-byte write. The byte enable is 1 << (address bits 1:0), and the byte is replicated on all four lanes.
- R5: After the copy, the word at descriptor offset 4 is written with all four byte enables. Its value is {16'h0011, packet size}: the flags become exactly bits 4 and 0, and the length becomes the packet size.
- R6: One cycle after that write is granted, `irq_set` equals 32'h0000_0002 (status bit 1) for exactly one cycle. At all other times it is zero.
- R7: If no descriptor qualifies in one full pass, `rx_drop` pulses for one cycle, nothing is written to memory and no interrupt is raised.
- R8: A packet of more than 1628 bytes is consumed to its last byte and then dropped with a one-cycle `rx_drop` pulse, without any memory access. A packet of exactly 1628 bytes is placed normally.
- R9: `s_ready` falls in the cycle after the last byte of an acceptable packet is taken. It stays low while any memory request is pending and rises again in the cycle in which the interrupt or drop pulse is presented.
- R10: If the ring has shrunk so that the running index is not below the new ring size, the search starts at the index modulo the ring size.
- R11: A memory request that is not granted keeps its address, direction, data and byte enables unchanged on the next cycle.
- R12: After reset, `s_ready` is 1, no memory request is pending, no pulse is given and the running index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | 32 | Byte address of descriptor 0 (4-byte aligned) |
| rx_ring_len_m1 | input | 16 | Receive ring size minus one (upper half of the ring-size register) |
| s_data | input | 8 | Packet byte |
| s_valid | input | 1 | Byte valid |
| s_last | input | 1 | Marks the final byte of a packet |
| s_ready | output | 1 | Engine can take a byte |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the access |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rx_drop | output | 1 | One-cycle pulse per discarded packet |
| irq_set | output | 32 | One-cycle mask of interrupt-status bits to set |

## Verification
A drop for an oversized packet is seen one cycle after its last byte is accepted. A drop for a full ring follows one cycle after the last length/flags read returns. The interrupt pulse follows one cycle after the grant of the descriptor write, and `s_ready` falls in the cycle after an acceptable last byte. The bench therefore reads `s_ready` at the falling edge just after the last byte, to confirm the stall. It then waits for `s_ready` to come back, plus three more falling edges, before comparing the pulse, read and write counts gathered by its memory model on every rising edge. Memory contents are compared only once the engine is idle again, and timing inside the wait is left to the bound properties on grant holding, pulse width and pulse origin.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int DESC_SHIFT  = 3;
  localparam int LENFLG_OFS  = 4;
  localparam int AVAIL_BIT   = 31;
  localparam logic [15:0] WB_FLAGS = 16'h0011;
  localparam int IRQ_RX_BIT  = 1;

  typedef enum logic [2:0] {
    S_CAP, S_NORM, S_LF, S_BA, S_FETCH, S_PUT, S_PWAIT, S_DWAIT
  } rx_state_t;
endpackage

// File: rtl/rxring_pkt_buf.sv
module rxring_pkt_buf #(
  parameter int DEPTH = 1628,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/rxring_index.sv
module rxring_index #(
  parameter int IDX_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] size,
  input  logic             norm,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] nxt,
  output logic             over
);
  logic [IDX_W-1:0] idx_q;

  assign idx  = idx_q;
  assign over = (idx_q >= size);
  assign nxt  = (idx_q + IDX_W'(1) == size) ? '0 : idx_q + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (rst)               idx_q <= '0;
    else if (norm && over) idx_q <= idx_q - size;
    else if (adv)          idx_q <= nxt;
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxring_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 16,
  parameter int MAX_PKT = 1628
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [SIZE_W-1:0] rx_ring_len_m1,
  input  logic [7:0]        s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              rx_drop,
  output logic [31:0]       irq_set
);
  localparam int LEN_W  = $clog2(MAX_PKT + 1);
  localparam int BUF_AW = $clog2(MAX_PKT);
  localparam int IDX_W  = SIZE_W + 1;

  rx_state_t         state_q;
  logic [LEN_W-1:0]  cnt_q, len_q, cp_q;
  logic              ovf_q;
  logic [IDX_W-1:0]  rsize_q, scan_q;
  logic [ADDR_W-1:0] desc_q, bufa_q;
  logic              req_q, we_q, ready_q, drop_q, irq_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       wdata_q;
  logic [3:0]        be_q;

  logic              take, buf_we, fits, cap_ok;
  logic [7:0]        buf_rdata;
  logic [IDX_W-1:0]  idx, idx_nxt;
  logic              idx_over;
  logic [ADDR_W-1:0] put_addr, cur_desc, nxt_desc;

  assign take     = s_valid && ready_q && (state_q == S_CAP);
  assign fits     = !ovf_q && (cnt_q < LEN_W'(MAX_PKT));
  assign buf_we   = take && fits;
  assign cap_ok   = mem_rdata[AVAIL_BIT] && (mem_rdata[15:0] >= 16'(len_q));
  assign put_addr = bufa_q + ADDR_W'(cp_q);
  assign cur_desc = ring_base + (ADDR_W'(idx) << DESC_SHIFT);
  assign nxt_desc = ring_base + (ADDR_W'(idx_nxt) << DESC_SHIFT);

  rxring_pkt_buf #(.DEPTH(MAX_PKT), .AW(BUF_AW)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (cnt_q[BUF_AW-1:0]),
    .wdata (s_data),
    .raddr (cp_q[BUF_AW-1:0]),
    .rdata (buf_rdata)
  );

  rxring_index #(.IDX_W(IDX_W)) u_idx (
    .clk  (clk),
    .rst  (rst),
    .size (rsize_q),
    .norm (state_q == S_NORM),
    .adv  ((state_q == S_LF) && mem_rvalid),
    .idx  (idx),
    .nxt  (idx_nxt),
    .over (idx_over)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_CAP;
      cnt_q   <= '0;
      len_q   <= '0;
      cp_q    <= '0;
      ovf_q   <= 1'b0;
      rsize_q <= IDX_W'(1);
      scan_q  <= '0;
      desc_q  <= '0;
      bufa_q  <= '0;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      ready_q <= 1'b1;
      drop_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      drop_q <= 1'b0;
      irq_q  <= 1'b0;
      case (state_q)
        S_CAP: begin
          if (take) begin
            if (fits) cnt_q <= cnt_q + LEN_W'(1);
            else      ovf_q <= 1'b1;
            if (s_last) begin
              cnt_q <= '0;
              ovf_q <= 1'b0;
              if (!fits) begin
                drop_q <= 1'b1;
              end else begin
                len_q   <= cnt_q + LEN_W'(1);
                rsize_q <= IDX_W'(rx_ring_len_m1) + IDX_W'(1);
                ready_q <= 1'b0;
                state_q <= S_NORM;
              end
            end
          end
        end
        S_NORM: begin
          if (!idx_over) begin
            req_q   <= 1'b1;
            we_q    <= 1'b0;
            be_q    <= 4'hF;
            addr_q  <= cur_desc + ADDR_W'(LENFLG_OFS);
            desc_q  <= cur_desc;
            scan_q  <= '0;
            state_q <= S_LF;
          end
        end
        S_LF: begin
          if (req_q && mem_gnt) req_q <= 1'b0;
          if (mem_rvalid) begin
            if (cap_ok) begin
              req_q   <= 1'b1;
              addr_q  <= desc_q;
              state_q <= S_BA;
            end else if (scan_q + IDX_W'(1) == rsize_q) begin
              drop_q  <= 1'b1;
              ready_q <= 1'b1;
              state_q <= S_CAP;
            end else begin
              req_q  <= 1'b1;
              addr_q <= nxt_desc + ADDR_W'(LENFLG_OFS);
              desc_q <= nxt_desc;
              scan_q <= scan_q + IDX_W'(1);
            end
          end
        end
        S_BA: begin
          if (req_q && mem_gnt) req_q <= 1'b0;
          if (mem_rvalid) begin
            bufa_q  <= mem_rdata[ADDR_W-1:0];
            cp_q    <= '0;
            state_q <= S_FETCH;
          end
        end
        S_FETCH: state_q <= S_PUT;
        S_PUT: begin
          req_q   <= 1'b1;
          we_q    <= 1'b1;
          addr_q  <= put_addr;
          be_q    <= 4'b0001 << put_addr[1:0];
          wdata_q <= {4{buf_rdata}};
          state_q <= S_PWAIT;
        end
        S_PWAIT: begin
          if (mem_gnt) begin
            if (cp_q + LEN_W'(1) == len_q) begin
              addr_q  <= desc_q + ADDR_W'(LENFLG_OFS);
              be_q    <= 4'hF;
              wdata_q <= {WB_FLAGS, 16'(len_q)};
              state_q <= S_DWAIT;
            end else begin
              req_q   <= 1'b0;
              cp_q    <= cp_q + LEN_W'(1);
              state_q <= S_FETCH;
            end
          end
        end
        S_DWAIT: begin
          if (mem_gnt) begin
            req_q   <= 1'b0;
            we_q    <= 1'b0;
            irq_q   <= 1'b1;
            ready_q <= 1'b1;
            state_q <= S_CAP;
          end
        end
        default: state_q <= S_CAP;
      endcase
    end
  end

  assign s_ready   = ready_q;
  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_be    = be_q;
  assign mem_wdata = wdata_q;
  assign rx_drop   = drop_q;
  assign irq_set   = irq_q ? (32'd1 << IRQ_RX_BIT) : 32'd0;
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk (
  input logic        clk,
  input logic        rst,
  input logic        s_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic        mem_gnt,
  input logic        rx_drop,
  input logic [31:0] irq_set
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata) && $stable(mem_be)));

  p_irq_code_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_set != 32'd0) |-> (irq_set == 32'h0000_0002));

  p_irq_origin_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_set != 32'd0) |-> $past(mem_req && mem_gnt && mem_we && mem_be == 4'hF));

  p_drop_single_r7: assert property (@(posedge clk) disable iff (rst)
    rx_drop |=> !rx_drop);

  p_drop_no_irq_r7: assert property (@(posedge clk) disable iff (rst)
    rx_drop |-> (irq_set == 32'd0));

  p_stall_input_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !s_ready);

  p_byte_lane_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_be != 4'hF) |->
      ($onehot(mem_be) && mem_be == (4'b0001 << mem_addr[1:0])));
endmodule

bind rx_ring_writer rx_ring_writer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .s_ready   (s_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata),
  .mem_gnt   (mem_gnt),
  .rx_drop   (rx_drop),
  .irq_set   (irq_set)
);

// File: tb/rx_ring_writer_test.sv
`timescale 1ns/1ps
module rx_ring_writer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ring_base = 32'd0;
  logic [15:0] rx_ring_len_m1 = 16'd3;
  logic [7:0]  s_data = 8'd0;
  logic        s_valid = 1'b0;
  logic        s_last = 1'b0;
  logic        s_ready, mem_req, mem_we, mem_gnt, mem_rvalid, rx_drop;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, irq_set;
  logic [3:0]  mem_be;

  always #2 clk = ~clk;

  rx_ring_writer uut (
    .clk(clk), .rst(rst), .ring_base(ring_base), .rx_ring_len_m1(rx_ring_len_m1),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .rx_drop(rx_drop), .irq_set(irq_set)
  );

  // memory model, host poke port and event counters
  logic [7:0]  mem [0:4095];
  logic        h_we = 1'b0;
  logic [11:0] h_addr = '0;
  logic [31:0] h_word = '0;
  logic        stall = 1'b0;
  logic        tog;
  int wr_cnt, rd_cnt, lf_cnt, irq_cnt, drop_cnt, bad_irq;

  assign mem_gnt = !stall || tog;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst) begin
      tog <= 1'b0;
      wr_cnt <= 0; rd_cnt <= 0; lf_cnt <= 0;
      irq_cnt <= 0; drop_cnt <= 0; bad_irq <= 0;
      mem_rdata <= '0;
    end else begin
      tog <= ~tog;
      if (mem_req && mem_gnt) begin
        if (mem_we) begin
          for (int l = 0; l < 4; l++)
            if (mem_be[l]) mem[{mem_addr[11:2], 2'(l)}] <= mem_wdata[8*l +: 8];
          wr_cnt <= wr_cnt + 1;
        end else begin
          mem_rdata <= {mem[{mem_addr[11:2], 2'd3}], mem[{mem_addr[11:2], 2'd2}],
                        mem[{mem_addr[11:2], 2'd1}], mem[{mem_addr[11:2], 2'd0}]};
          mem_rvalid <= 1'b1;
          rd_cnt <= rd_cnt + 1;
          if (mem_addr[2]) lf_cnt <= lf_cnt + 1;
        end
      end
      if (irq_set != 0) irq_cnt <= irq_cnt + 1;
      if (irq_set != 0 && irq_set != 32'h2) bad_irq <= bad_irq + 1;
      if (rx_drop) drop_cnt <= drop_cnt + 1;
    end
    if (h_we) for (int l = 0; l < 4; l++) mem[{h_addr[11:2], 2'(l)}] <= h_word[8*l +: 8];
  end

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] peek32(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic poke32(input int a, input logic [31:0] w);
    @(negedge clk); h_we = 1'b1; h_addr = 12'(a); h_word = w;
    @(negedge clk); h_we = 1'b0;
  endtask

  task automatic set_desc(input int slot, input int bufa, input int cap, input logic [15:0] fl);
    poke32(slot * 8, 32'(bufa));
    poke32(slot * 8 + 4, {fl, 16'(cap)});
  endtask

  task automatic fill(input int a0, input int a1);
    for (int a = a0; a < a1; a += 4) poke32(a, 32'hEEEE_EEEE);
  endtask

  task automatic send_pkt(input int len, input int seed, output logic rdy_after);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      while (!s_ready) @(negedge clk);
      s_valid = 1'b1; s_data = 8'(seed + i); s_last = (i == len - 1);
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
    rdy_after = s_ready;
  endtask

  task automatic wait_idle();
    while (!s_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic int data_errs(input int bufa, input int len, input int seed);
    int e = 0;
    for (int i = 0; i < len; i++) if (mem[bufa + i] != 8'(seed + i)) e++;
    return e;
  endfunction

  // vector: len[63:52] avail[51:48] cap3..cap0[47:16] slot[15:13](4=drop) reads[12:10]
  localparam logic [63:0] VEC [0:7] = '{
    {12'd10, 4'b1111, 8'd64, 8'd64, 8'd64, 8'd64, 3'd0, 3'd1, 10'd0},
    {12'd20, 4'b1111, 8'd64, 8'd64, 8'd10, 8'd64, 3'd2, 3'd2, 10'd0},
    {12'd30, 4'b0110, 8'd64, 8'd64, 8'd64, 8'd64, 3'd1, 3'd3, 10'd0},
    {12'd40, 4'b1111, 8'd64, 8'd40, 8'd64, 8'd64, 3'd2, 3'd1, 10'd0},
    {12'd50, 4'b0000, 8'd64, 8'd64, 8'd64, 8'd64, 3'd4, 3'd4, 10'd0},
    {12'd60, 4'b1111, 8'd59, 8'd59, 8'd59, 8'd59, 3'd4, 3'd4, 10'd0},
    {12'd1,  4'b1000, 8'd64, 8'd64, 8'd64, 8'd64, 3'd3, 3'd1, 10'd0},
    {12'd64, 4'b1111, 8'd64, 8'd64, 8'd64, 8'd63, 3'd1, 3'd2, 10'd0}
  };

  initial begin
    logic rdy;
    int w0, r0, l0, i0, d0, e;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 ready", 32'(s_ready), 32'd1);
    chk("R12 req", 32'(mem_req), 32'd0);
    chk("R12 pulses", {irq_set[30:0], rx_drop}, 32'd0);

    rx_ring_len_m1 = 16'd3;
    for (int v = 0; v < 8; v++) begin
      logic [63:0] t;
      int len, slot, reads, seed;
      logic [15:0] fl [4];
      int cp [4];
      t = VEC[v];
      len = int'(t[63:52]); slot = int'(t[15:13]); reads = int'(t[12:10]);
      seed = v * 16 + 1;
      stall = (v >= 4);
      for (int s = 0; s < 4; s++) begin
        fl[s] = t[48 + s] ? 16'h8000 : 16'h0000;
        cp[s] = int'(t[16 + 8*s +: 8]);
        set_desc(s, 32'h100 + s * 32'h80, cp[s], fl[s]);
      end
      fill(32'h100, 32'h300);
      w0 = wr_cnt; l0 = lf_cnt; i0 = irq_cnt; d0 = drop_cnt;
      send_pkt(len, seed, rdy);
      wait_idle();
      if (slot == 4) begin
        chk("R7 drop pulse", 32'(drop_cnt - d0), 32'd1);
        chk("R7 no irq", 32'(irq_cnt - i0), 32'd0);
        chk("R7 no writes", 32'(wr_cnt - w0), 32'd0);
        chk("R1 full pass reads", 32'(lf_cnt - l0), 32'(reads));
      end else begin
        chk("R6 irq pulse", 32'(irq_cnt - i0), 32'd1);
        chk("R3 no drop", 32'(drop_cnt - d0), 32'd0);
        chk("R2 inspected", 32'(lf_cnt - l0), 32'(reads));
        chk("R5 writeback", peek32(slot * 8 + 4), {16'h0011, 16'(len)});
        chk("R4 data", 32'(data_errs(32'h100 + slot * 32'h80, len, seed)), 32'd0);
        chk("R4 guard", 32'(mem[32'h100 + slot * 32'h80 + len]), 32'hEE);
        e = 0;
        for (int s = 0; s < 4; s++)
          if (s != slot && peek32(s * 8 + 4) != {fl[s], 16'(cp[s])}) e++;
        chk("R3 others untouched", 32'(e), 32'd0);
      end
    end
    stall = 1'b0;
    chk("R6 irq value", 32'(bad_irq), 32'd0);

    // R8: oversize packet, index stays at 2
    r0 = rd_cnt; w0 = wr_cnt; d0 = drop_cnt;
    send_pkt(1629, 5, rdy);
    wait_idle();
    chk("R8 oversize ready", 32'(rdy), 32'd1);
    chk("R8 oversize drop", 32'(drop_cnt - d0), 32'd1);
    chk("R8 oversize no access", 32'((rd_cnt - r0) + (wr_cnt - w0)), 32'd0);

    // R8: maximum packet in slot 2
    for (int s = 0; s < 4; s++) set_desc(s, 32'h100, 64, 16'h0000);
    set_desc(2, 32'h800, 1628, 16'h8000);
    fill(32'h800, 32'hE60);
    i0 = irq_cnt; l0 = lf_cnt;
    send_pkt(1628, 9, rdy);
    chk("R9 ready low after last", 32'(rdy), 32'd0);
    wait_idle();
    chk("R9 ready back", 32'(s_ready), 32'd1);
    chk("R8 max irq", 32'(irq_cnt - i0), 32'd1);
    chk("R8 max inspected", 32'(lf_cnt - l0), 32'd1);
    chk("R8 max writeback", peek32(2 * 8 + 4), {16'h0011, 16'd1628});
    chk("R8 max data", 32'(data_errs(32'h800, 1628, 9)), 32'd0);

    // R10: grow ring to 8, take slot 6, shrink to 3 -> start at 7 mod 3 = 1
    rx_ring_len_m1 = 16'd7;
    for (int s = 0; s < 8; s++) set_desc(s, 32'h100 + s * 32'h40, 32, (s == 6) ? 16'h8000 : 16'h0000);
    l0 = lf_cnt;
    send_pkt(8, 3, rdy);
    wait_idle();
    chk("R2 eight ring inspected", 32'(lf_cnt - l0), 32'd4);
    chk("R2 eight ring slot6", peek32(6 * 8 + 4), {16'h0011, 16'd8});
    rx_ring_len_m1 = 16'd2;
    for (int s = 0; s < 3; s++) set_desc(s, 32'h100 + s * 32'h40, 32, 16'h8000);
    l0 = lf_cnt;
    send_pkt(5, 7, rdy);
    wait_idle();
    chk("R10 modulo start", peek32(1 * 8 + 4), {16'h0011, 16'd5});
    chk("R10 slot0 untouched", peek32(0 * 8 + 4), {16'h8000, 16'd32});
    chk("R10 inspected", 32'(lf_cnt - l0), 32'd1);
    chk("R11 irq value", 32'(bad_irq), 32'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule